// File: doc/BRIEF.md
# Decimating FIR Tap Cell

This block is a single tap of a cascadable FIR filter. A coefficient arrives from the previous tap and is captured in a coefficient register. From there it runs through a short chain of delay stages and leaves the cell for the next tap. A signal sample arrives on a shared data bus and is captured in a data register. On each enabled clock, the cell multiplies the stored sample by the stored coefficient and adds the product into a wide two's complement accumulator.

A select input sets how many delay stages the outgoing coefficient passes through: none, one, two or three. With this setting, a chain of cells built from this tap can lower its output rate to one half, one third or one quarter of the input rate. The coefficient and the sample each have their own format control. An operand can be read either as an 8-bit unsigned value or as a 9-bit two's complement value.

Top module: `fir_tap_cell`

## Requirements
- R1: A synchronous active-high reset clears the data register, the coefficient register, all three delay stages and the accumulator, so after a reset edge `acc_out` is 0 and `cout` is 0 for every `dec_sel` value. Reset takes priority over every enable.
- R2: On a clock edge with `cin_en` high, the coefficient register loads `cin`. With `dec_sel` = 0, `cout` shows that value right after the edge.
- R3: With `dec_sel` = k (binary, k = 0..3), `cout` equals the coefficient that was loaded k `cin_en` edges before the most recent one. This is the value of delay stage k, where stage 0 is the coefficient register. Each enabled edge moves every stage one place along. Stages that have not yet been filled since reset read 0.
- R4: On an edge with `cin_en` low, the coefficient register and all delay stages hold their values, whatever `cin` is.
- R5: On an edge with `din_en` high and `erase` low, the accumulator adds the product of the data register and the coefficient register, as both stood before the edge. On the same edge the data register loads `din`. The accumulator is 26 bits wide and wraps modulo 2^26.
- R6: On an edge with `din_en` low, the data register and the accumulator both hold their values.
- R7: On an edge with `erase` high, the accumulator becomes 0 and nothing is added, even when `din_en` is high. The data register still loads `din` if `din_en` is high.
- R8: When `data_signed` is 1, the 9-bit sample is read as two's complement. When it is 0, bit 8 is ignored and bits 7:0 are read as unsigned. `coef_signed` selects the same two formats for the coefficient. The two format controls are independent of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 9 | Signal sample from the shared data bus |
| din_en | input | 1 | Loads the sample and enables accumulation |
| data_signed | input | 1 | 1: sample is two's complement, 0: 8-bit unsigned |
| cin | input | 9 | Coefficient from the previous tap |
| cin_en | input | 1 | Advances the coefficient register and the delay stages |
| coef_signed | input | 1 | 1: coefficient is two's complement, 0: 8-bit unsigned |
| dec_sel | input | 2 | Number of delay stages on the outgoing coefficient |
| erase | input | 1 | Clears the accumulator on the next edge |
| cout | output | 9 | Coefficient passed to the next tap |
| acc_out | output | 26 | Accumulator value |

## Verification
The bench builds the cell with its default parameters: 9-bit operands, a 26-bit accumulator and three delay stages. These values bring every code of the 2-bit select into reach, and they place the format bit at bit 8 of both operands, which is where the unsigned and signed readings differ. For each select code combined with each of the four format pairs, the bench streams a sequence of coefficients and samples in which bit 8 is often set. It compares the delayed outgoing coefficient at every step, and it compares the accumulator against a dot product that the bench computes itself.

// File: rtl/fir_cell_pkg.sv
package fir_cell_pkg;

  // Outgoing coefficient delay, as encoded on the select input
  typedef enum logic [1:0] {
    DEC_BY_1 = 2'd0,
    DEC_BY_2 = 2'd1,
    DEC_BY_3 = 2'd2,
    DEC_BY_4 = 2'd3
  } dec_rate_e;

  localparam int DEF_OPND_W = 9;
  localparam int DEF_ACC_W  = 26;
  localparam int DEF_STAGES = 3;

endpackage

// File: rtl/fir_operand_fmt.sv
module fir_operand_fmt #(
  parameter int W = 9
) (
  input  logic [W-1:0]        raw,
  input  logic                is_signed,
  output logic signed [W-1:0] val
);

  // Unsigned: the top bit is dropped and the low W-1 bits are zero-extended
  always_comb begin
    if (is_signed) val = raw;
    else           val = {1'b0, raw[W-2:0]};
  end

endmodule

// File: rtl/fir_coef_path.sv
module fir_coef_path #(
  parameter int W      = 9,
  parameter int STAGES = 3,
  localparam int SELW  = $clog2(STAGES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cin_en,
  input  logic [W-1:0]    cin,
  input  logic [SELW-1:0] dec_sel,
  output logic [W-1:0]    coef_q,
  output logic [W-1:0]    first_delay,
  output logic [W-1:0]    cout
);

  // stage[0] holds the active coefficient; the higher stages are the delays
  logic [W-1:0] stage [0:STAGES];

  always_ff @(posedge clk) begin
    if (rst)         stage[0] <= '0;
    else if (cin_en) stage[0] <= cin;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_delay
    always_ff @(posedge clk) begin
      if (rst)         stage[i] <= '0;
      else if (cin_en) stage[i] <= stage[i-1];
    end
  end

  always_comb begin
    cout = stage[0];
    for (int i = 1; i <= STAGES; i++) begin
      if (dec_sel == SELW'(i)) cout = stage[i];
    end
  end

  assign coef_q      = stage[0];
  assign first_delay = stage[1];

endmodule

// File: rtl/fir_mac_acc.sv
module fir_mac_acc #(
  parameter int DW   = 9,
  parameter int CW   = 9,
  parameter int ACCW = 26,
  localparam int PW  = DW + CW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   erase,
  input  logic                   din_en,
  input  logic signed [DW-1:0]   a,
  input  logic signed [CW-1:0]   b,
  output logic signed [ACCW-1:0] acc
);

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext;

  assign prod     = a * b;
  assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst || erase) acc <= '0;
    else if (din_en)  acc <= acc + prod_ext;
  end

endmodule

// File: rtl/fir_tap_cell.sv
module fir_tap_cell
  import fir_cell_pkg::*;
#(
  parameter int DATA_W   = DEF_OPND_W,
  parameter int COEF_W   = DEF_OPND_W,
  parameter int ACC_W    = DEF_ACC_W,
  parameter int STAGES   = DEF_STAGES,
  localparam int SEL_W   = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              din_en,
  input  logic              data_signed,
  input  logic [COEF_W-1:0] cin,
  input  logic              cin_en,
  input  logic              coef_signed,
  input  logic [SEL_W-1:0]  dec_sel,
  input  logic              erase,
  output logic [COEF_W-1:0] cout,
  output logic [ACC_W-1:0]  acc_out
);

  logic [DATA_W-1:0]        data_q;
  logic [COEF_W-1:0]        coef_now;
  logic [COEF_W-1:0]        tap1;
  logic signed [DATA_W-1:0] data_op;
  logic signed [COEF_W-1:0] coef_op;
  logic signed [ACC_W-1:0]  acc_s;

  always_ff @(posedge clk) begin
    if (rst)         data_q <= '0;
    else if (din_en) data_q <= din;
  end

  fir_coef_path #(.W(COEF_W), .STAGES(STAGES)) u_coef (
    .clk         (clk),
    .rst         (rst),
    .cin_en      (cin_en),
    .cin         (cin),
    .dec_sel     (dec_sel),
    .coef_q      (coef_now),
    .first_delay (tap1),
    .cout        (cout)
  );

  fir_operand_fmt #(.W(DATA_W)) u_dfmt (
    .raw       (data_q),
    .is_signed (data_signed),
    .val       (data_op)
  );

  fir_operand_fmt #(.W(COEF_W)) u_cfmt (
    .raw       (coef_now),
    .is_signed (coef_signed),
    .val       (coef_op)
  );

  fir_mac_acc #(.DW(DATA_W), .CW(COEF_W), .ACCW(ACC_W)) u_mac (
    .clk    (clk),
    .rst    (rst),
    .erase  (erase),
    .din_en (din_en),
    .a      (data_op),
    .b      (coef_op),
    .acc    (acc_s)
  );

  assign acc_out = acc_s;

endmodule

// File: rtl/fir_tap_cell_chk.sv
module fir_tap_cell_chk #(
  parameter int CW   = 9,
  parameter int ACCW = 26
) (
  input logic            clk,
  input logic            rst,
  input logic            cin_en,
  input logic            din_en,
  input logic            erase,
  input logic [CW-1:0]   cin,
  input logic [CW-1:0]   coef_now,
  input logic [CW-1:0]   tap1,
  input logic [ACCW-1:0] acc_out
);

  // R1: a reset edge leaves a cleared accumulator and coefficient register
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && coef_now == '0));

  p_coef_load_r2: assert property (@(posedge clk) disable iff (rst)
    cin_en |=> coef_now == $past(cin));

  p_delay_shift_r3: assert property (@(posedge clk) disable iff (rst)
    cin_en |=> tap1 == $past(coef_now));

  p_coef_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cin_en |=> ($stable(coef_now) && $stable(tap1)));

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!din_en && !erase) |=> $stable(acc_out));

  p_erase_clear_r7: assert property (@(posedge clk) disable iff (rst)
    erase |=> acc_out == '0);

endmodule

bind fir_tap_cell fir_tap_cell_chk #(.CW(COEF_W), .ACCW(ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cin_en   (cin_en),
  .din_en   (din_en),
  .erase    (erase),
  .cin      (cin),
  .coef_now (coef_now),
  .tap1     (tap1),
  .acc_out  (acc_out)
);

// File: tb/fir_tap_cell_test.sv
module fir_tap_cell_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  din;
  logic        din_en;
  logic        data_signed;
  logic [8:0]  cin;
  logic        cin_en;
  logic        coef_signed;
  logic [1:0]  dec_sel;
  logic        erase;
  logic [8:0]  cout;
  logic [25:0] acc_out;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_tap_cell uut (
    .clk(clk), .rst(rst), .din(din), .din_en(din_en), .data_signed(data_signed),
    .cin(cin), .cin_en(cin_en), .coef_signed(coef_signed), .dec_sel(dec_sel),
    .erase(erase), .cout(cout), .acc_out(acc_out)
  );

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint acc_val();
    return longint'($signed(acc_out));
  endfunction

  // Operand value per R8
  function automatic longint opv(logic [8:0] x, logic s);
    if (s) return longint'($signed(x));
    return longint'(x[7:0]);
  endfunction

  // One clock: inputs applied at the falling edge, results read at the next one
  task automatic cyc(logic [8:0] d, logic de, logic [8:0] c, logic ce, logic er);
    din = d; din_en = de; cin = c; cin_en = ce; erase = er;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(9'h155, 1'b1, 9'h0AA, 1'b1, 1'b0);
    cyc(9'h0F3, 1'b1, 9'h123, 1'b1, 1'b0);
    rst = 1'b0;
  endtask

  function automatic logic [8:0] xs(int k, int salt);
    return 9'((k * 37 + 11 + 5 * salt) & 511);
  endfunction

  function automatic logic [8:0] cs(int k, int salt);
    return 9'((k * 53 + 200 + 3 * salt) & 511);
  endfunction

  task automatic t_reset();
    do_reset();
    for (int s = 0; s < 4; s++) begin
      dec_sel = 2'(s);
      #1;
      chk("R1 cout after reset", longint'(cout), 0);
    end
    chk("R1 acc after reset", acc_val(), 0);
  endtask

  // R3/R5/R8: stream for each select code and each format pair
  task automatic t_stream(int sel, logic ds, logic csg);
    longint exp_acc = 0;
    int n = 12;
    dec_sel = 2'(sel); data_signed = ds; coef_signed = csg;
    do_reset();
    for (int k = 1; k <= n; k++) begin
      cyc(xs(k, sel), 1'b1, cs(k, sel), 1'b1, 1'b0);
      if (k >= 2) exp_acc += opv(xs(k-1, sel), ds) * opv(cs(k-1, sel), csg);
      if (k - sel >= 1) chk("R3 delayed cout", longint'(cout), longint'(cs(k - sel, sel)));
      else              chk("R3 unfilled stage", longint'(cout), 0);
    end
    chk("R5 R8 accumulated dot product", acc_val(), exp_acc);
  endtask

  task automatic t_load_hold();
    dec_sel = 2'd0;
    do_reset();
    cyc(9'h0, 1'b0, 9'h011, 1'b1, 1'b0);
    chk("R2 coef load", longint'(cout), 17);
    cyc(9'h0, 1'b0, 9'h022, 1'b1, 1'b0);
    cyc(9'h0, 1'b0, 9'h033, 1'b1, 1'b0);
    cyc(9'h0, 1'b0, 9'h044, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc(9'h0, 1'b0, 9'(9'h1F0 + i), 1'b0, 1'b0);
    chk("R4 coef reg held", longint'(cout), 9'h044);
    dec_sel = 2'd3; #1;
    chk("R4 last stage held", longint'(cout), 9'h011);
    dec_sel = 2'd1; #1;
    chk("R4 first stage held", longint'(cout), 9'h033);
  endtask

  task automatic t_acc_hold_erase();
    data_signed = 1'b1; coef_signed = 1'b1; dec_sel = 2'd0;
    do_reset();
    cyc(9'd3, 1'b1, 9'd5, 1'b1, 1'b0);
    chk("R5 first product uses cleared data", acc_val(), 0);
    cyc(9'd7, 1'b1, 9'd0, 1'b0, 1'b0);
    chk("R5 add 3*5", acc_val(), 15);
    for (int i = 0; i < 3; i++) cyc(9'(100 + i), 1'b0, 9'd0, 1'b0, 1'b0);
    chk("R6 acc held with din_en low", acc_val(), 15);
    cyc(9'd200, 1'b1, 9'd0, 1'b0, 1'b0);
    chk("R6 data reg held, adds 7*5", acc_val(), 50);
    cyc(9'd9, 1'b1, 9'd0, 1'b0, 1'b1);
    chk("R7 erase with din_en high", acc_val(), 0);
    cyc(9'd1, 1'b1, 9'd0, 1'b0, 1'b0);
    chk("R7 data loaded during erase, adds 9*5", acc_val(), 45);
  endtask

  task automatic t_formats();
    for (int f = 0; f < 4; f++) begin
      data_signed = f[0]; coef_signed = f[1];
      do_reset();
      cyc(9'h1FF, 1'b1, 9'h1FF, 1'b1, 1'b0);
      cyc(9'h000, 1'b1, 9'h000, 1'b0, 1'b0);
      chk("R8 format pair 0x1FF*0x1FF", acc_val(),
          opv(9'h1FF, f[0]) * opv(9'h1FF, f[1]));
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst = 1'b1; din = '0; din_en = 1'b0; cin = '0; cin_en = 1'b0;
    data_signed = 1'b0; coef_signed = 1'b0; dec_sel = 2'd0; erase = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_hold();
    t_acc_hold_erase();
    t_formats();
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++)
        t_stream(s, f[0], f[1]);
    t_reset();
    finish_run();
  end

endmodule